// File: doc/BRIEF.md
# Backdoor Key Security Unlock

This block holds the security options byte of a flash controller and offers a way to temporarily lift device security using a secret key. Every reset copies a nonvolatile option byte into the options register. After that, nothing else can change the register until the next reset. The register holds four fields: a backdoor-enable bit, a vector-redirection disable bit, an EEPROM program-mode bit and a two-bit security field.

While the security field reports a secured part and the backdoor is enabled, user firmware can pulse a start trigger and then write eight candidate key bytes. Each write carries its byte index and a flag that tells whether it came from the debug port. The block compares every byte, as it arrives, against the matching byte of the stored nonvolatile key, in ascending byte order.

When all eight bytes match, the part reads as unsecured until the next reset. Any of the following aborts the attempt:
- a write from the debug port;
- a write with an unexpected index.

A byte with wrong data blocks every further attempt until reset.

Top module: `sec_backdoor_unlock`

## Requirements
- R1: On every cycle with `rst_n` low, `opt_o` is loaded with `nv_opt_i`, with bits 4:2 forced to 0. After reset it stays unchanged whatever the other inputs do.
- R2: `opt_o` bit 7 is the backdoor enable, bit 6 the redirection disable, bit 5 the EEPROM program-mode bit (passed through) and bits 1:0 the security field. `redir_en_o` is high exactly when bit 6 is 0.
- R3: `secured_o` is high when the security field differs from 2'b10 and no unlock has happened since reset. It is low whenever the field is 2'b10.
- R4: A `start_i` pulse arms an attempt at byte index 0 only when bit 7 is 1, the field is secured, and the block is neither blocked nor unlocked. Key writes made while not armed are ignored.
- R5: A write is accepted when all of the following hold: `kw_valid_i` is high, the block is armed, `kw_dbg_i` is 0, and `kw_idx_i` equals the expected index. Its `kw_data_i` must equal stored byte i, which is `nv_key_i[8*i+7:8*i]`. The expected index then advances by one.
- R6: After the byte with index 7 is accepted, `unlock_o` is high and `secured_o` low from the next cycle. Both stay that way until reset.
- R7: With bit 7 of the options at 0, no write sequence ever raises `unlock_o`.
- R8: A write with `kw_dbg_i` = 1 while armed aborts the attempt: the block is disarmed with index 0, and the byte never counts toward an unlock.
- R9: A write whose index differs from the expected one aborts the attempt in the same way as R8.
- R10: A write with the expected index but wrong data blocks the backdoor: later `start_i` pulses are ignored until reset.
- R11: When `start_i` and a key write fall in the same cycle, the start wins. The write is discarded and the attempt restarts at index 0.
- R12: A reset ends an unlock, and `secured_o` again follows the security field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; loads the options register |
| nv_opt_i | input | 8 | Nonvolatile option byte |
| nv_key_i | input | 64 | Nonvolatile key; byte i at bits 8*i+7:8*i |
| start_i | input | 1 | Start pulse that arms an unlock attempt |
| kw_valid_i | input | 1 | Key byte write strobe |
| kw_dbg_i | input | 1 | 1 when the write comes from the debug port |
| kw_idx_i | input | 3 | Index of the key byte written |
| kw_data_i | input | 8 | Key byte value |
| opt_o | output | 8 | Options register value |
| redir_en_o | output | 1 | Vector redirection active |
| secured_o | output | 1 | Part is secured |
| unlock_o | output | 1 | Backdoor unlock in effect |

## Verification
The start trigger and a key byte write can land on the same clock edge, where start must win and the byte must be dropped. The bench arms an attempt and feeds four correct bytes. It then raises `start_i` together with a write of index 4 carrying wrong data.

The outcome is judged at the ports in two steps:
- A full correct sequence starting at index 0 must then unlock. This shows that the colliding byte neither blocked the backdoor nor advanced the index.
- Before the eighth byte, `unlock_o` must still be low.

// File: rtl/sbu_pkg.sv
package sbu_pkg;
    typedef enum logic [1:0] {
        SQ_IDLE    = 2'd0,
        SQ_ARMED   = 2'd1,
        SQ_BLOCKED = 2'd2,
        SQ_OPEN    = 2'd3
    } sq_mode_e;
endpackage

// File: rtl/sbu_opt_reg.sv
module sbu_opt_reg #(
    parameter int OPT_W  = 8,
    parameter int RSV_HI = 4,
    parameter int RSV_LO = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OPT_W-1:0] nv_opt_i,
    output logic [OPT_W-1:0] opt_o
);
    localparam int RSV_N = RSV_HI - RSV_LO + 1;
    localparam logic [OPT_W-1:0] RSV_MASK = OPT_W'(((1 << RSV_N) - 1) << RSV_LO);

    logic [OPT_W-1:0] opt_d, opt_q;

    // Outside reset the register only holds its value.
    always_comb begin
        opt_d = opt_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) opt_q <= nv_opt_i & ~RSV_MASK;
        else        opt_q <= opt_d;
    end

    assign opt_o = opt_q;
endmodule

// File: rtl/sbu_key_sel.sv
module sbu_key_sel #(
    parameter int NB = 8,
    parameter int BW = 8,
    parameter int IW = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic [NB*BW-1:0] nv_key_i,
    input  logic [IW-1:0]    idx_i,
    input  logic [BW-1:0]    data_i,
    output logic             match_o
);
    logic [NB-1:0] hit;

    // One comparator per key byte; only the addressed one may report a hit.
    for (genvar g = 0; g < NB; g++) begin : g_byte
        assign hit[g] = (idx_i == IW'(g)) && (nv_key_i[g*BW +: BW] == data_i);
    end

    assign match_o = |hit;
endmodule

// File: rtl/sbu_seq.sv
module sbu_seq
    import sbu_pkg::*;
#(
    parameter int NB = 8,
    parameter int IW = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          gate_ok_i,
    input  logic          start_i,
    input  logic          kw_valid_i,
    input  logic          kw_dbg_i,
    input  logic [IW-1:0] kw_idx_i,
    input  logic          byte_ok_i,
    output logic [IW-1:0] idx_o,
    output logic          open_o
);
    localparam logic [IW-1:0] LAST = IW'(NB - 1);

    typedef struct packed {
        sq_mode_e      mode;
        logic [IW-1:0] idx;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start_i && gate_ok_i &&
            (st_q.mode == SQ_IDLE || st_q.mode == SQ_ARMED)) begin
            // Start has priority over a write in the same cycle.
            st_d.mode = SQ_ARMED;
            st_d.idx  = '0;
        end else if (kw_valid_i && st_q.mode == SQ_ARMED) begin
            if (kw_dbg_i || kw_idx_i != st_q.idx) begin
                st_d.mode = SQ_IDLE;
                st_d.idx  = '0;
            end else if (!byte_ok_i) begin
                st_d.mode = SQ_BLOCKED;
                st_d.idx  = '0;
            end else if (st_q.idx == LAST) begin
                st_d.mode = SQ_OPEN;
                st_d.idx  = '0;
            end else begin
                st_d.idx = st_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mode <= SQ_IDLE;
            st_q.idx  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign idx_o  = st_q.idx;
    assign open_o = (st_q.mode == SQ_OPEN);
endmodule

// File: rtl/sec_backdoor_unlock.sv
module sec_backdoor_unlock #(
    parameter int KEY_BYTES = 8,
    parameter int BYTE_W    = 8,
    parameter int OPT_W     = 8,
    parameter int ENA_BIT   = 7,
    parameter int NORED_BIT = 6,
    parameter int RSV_HI    = 4,
    parameter int RSV_LO    = 2,
    parameter int SEC_LSB   = 0,
    parameter int SEC_W     = 2,
    parameter logic [SEC_W-1:0] UNSEC_CODE = 2'b10,
    localparam int IDX_W    = (KEY_BYTES > 1) ? $clog2(KEY_BYTES) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [OPT_W-1:0]            nv_opt_i,
    input  logic [KEY_BYTES*BYTE_W-1:0] nv_key_i,
    input  logic                        start_i,
    input  logic                        kw_valid_i,
    input  logic                        kw_dbg_i,
    input  logic [IDX_W-1:0]            kw_idx_i,
    input  logic [BYTE_W-1:0]           kw_data_i,
    output logic [OPT_W-1:0]            opt_o,
    output logic                        redir_en_o,
    output logic                        secured_o,
    output logic                        unlock_o
);
    logic [OPT_W-1:0] opt;
    logic [IDX_W-1:0] exp_idx;
    logic             byte_ok;
    logic             open;
    logic             field_sec;
    logic             gate_ok;

    sbu_opt_reg #(
        .OPT_W  (OPT_W),
        .RSV_HI (RSV_HI),
        .RSV_LO (RSV_LO)
    ) opt_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .nv_opt_i (nv_opt_i),
        .opt_o    (opt)
    );

    // Compare the written byte against the stored byte at the expected index.
    sbu_key_sel #(
        .NB (KEY_BYTES),
        .BW (BYTE_W),
        .IW (IDX_W)
    ) key_i (
        .nv_key_i (nv_key_i),
        .idx_i    (exp_idx),
        .data_i   (kw_data_i),
        .match_o  (byte_ok)
    );

    sbu_seq #(
        .NB (KEY_BYTES),
        .IW (IDX_W)
    ) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .gate_ok_i  (gate_ok),
        .start_i    (start_i),
        .kw_valid_i (kw_valid_i),
        .kw_dbg_i   (kw_dbg_i),
        .kw_idx_i   (kw_idx_i),
        .byte_ok_i  (byte_ok),
        .idx_o      (exp_idx),
        .open_o     (open)
    );

    assign field_sec  = (opt[SEC_LSB +: SEC_W] != UNSEC_CODE);
    assign gate_ok    = opt[ENA_BIT] && field_sec;
    assign opt_o      = opt;
    assign redir_en_o = ~opt[NORED_BIT];
    assign secured_o  = field_sec && !open;
    assign unlock_o   = open;
endmodule

// File: rtl/sbu_chk.sv
module sbu_chk #(
    parameter int OPT_W     = 8,
    parameter int ENA_BIT   = 7,
    parameter int NORED_BIT = 6,
    parameter int RSV_HI    = 4,
    parameter int RSV_LO    = 2,
    parameter int SEC_LSB   = 0,
    parameter int SEC_W     = 2,
    parameter logic [SEC_W-1:0] UNSEC_CODE = 2'b10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             kw_valid_i,
    input logic             kw_dbg_i,
    input logic [OPT_W-1:0] opt_o,
    input logic             redir_en_o,
    input logic             secured_o,
    input logic             unlock_o
);
    // R1
    opt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(opt_o));

    // R1
    rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        opt_o[RSV_HI:RSV_LO] == '0);

    // R2
    redir_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redir_en_o == !opt_o[NORED_BIT]);

    // R3
    unsec_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (opt_o[SEC_LSB +: SEC_W] == UNSEC_CODE) |-> !secured_o);

    // R6
    open_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unlock_o |=> unlock_o);

    // R6
    open_unsec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unlock_o |-> !secured_o);

    // R7
    ena_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !opt_o[ENA_BIT] |-> !unlock_o);

    // R8
    user_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlock_o) |-> $past(kw_valid_i && !kw_dbg_i));
endmodule

bind sec_backdoor_unlock sbu_chk #(
    .OPT_W      (OPT_W),
    .ENA_BIT    (ENA_BIT),
    .NORED_BIT  (NORED_BIT),
    .RSV_HI     (RSV_HI),
    .RSV_LO     (RSV_LO),
    .SEC_LSB    (SEC_LSB),
    .SEC_W      (SEC_W),
    .UNSEC_CODE (UNSEC_CODE)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .kw_valid_i (kw_valid_i),
    .kw_dbg_i   (kw_dbg_i),
    .opt_o      (opt_o),
    .redir_en_o (redir_en_o),
    .secured_o  (secured_o),
    .unlock_o   (unlock_o)
);

// File: tb/sec_backdoor_unlock_tb.sv
`timescale 1ns/1ps
module sec_backdoor_unlock_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  nv_opt = 8'h00;
    logic [63:0] nv_key = '0;
    logic        start = 1'b0;
    logic        kw_valid = 1'b0;
    logic        kw_dbg = 1'b0;
    logic [2:0]  kw_idx = '0;
    logic [7:0]  kw_data = '0;
    logic [7:0]  opt;
    logic        redir_en, secured, unlock;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sec_backdoor_unlock dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .nv_opt_i   (nv_opt),
        .nv_key_i   (nv_key),
        .start_i    (start),
        .kw_valid_i (kw_valid),
        .kw_dbg_i   (kw_dbg),
        .kw_idx_i   (kw_idx),
        .kw_data_i  (kw_data),
        .opt_o      (opt),
        .redir_en_o (redir_en),
        .secured_o  (secured),
        .unlock_o   (unlock)
    );

    function automatic logic [7:0] kb(int i);
        return 8'((8'h3C + i * 8'h47) ^ 8'h5A);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset(logic [7:0] o);
        @(negedge clk);
        rst_n = 1'b0; nv_opt = o;
        start = 1'b0; kw_valid = 1'b0; kw_dbg = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wr(int idx, logic [7:0] d, logic dbg);
        @(negedge clk);
        kw_valid = 1'b1; kw_idx = 3'(idx); kw_data = d; kw_dbg = dbg;
        @(negedge clk);
        kw_valid = 1'b0; kw_dbg = 1'b0;
    endtask

    task automatic wr_range(int from, int to, logic dbg);
        for (int i = from; i <= to; i++) wr(i, kb(i), dbg);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog act=timeout exp=finish");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 8; i++) nv_key[i*8 +: 8] = kb(i);

        // R1 R2 R3: sweep every option byte through reset
        for (int o = 0; o < 256; o++) begin
            do_reset(8'(o));
            check("R1 opt load", 32'(opt), 32'(8'(o) & 8'hE3));
            check("R2 redir", 32'(redir_en), 32'(!o[6]));
            check("R3 secured", 32'(secured), 32'(o[1:0] != 2'b10));
            check("R12 unlock at reset", 32'(unlock), 0);
        end

        // R5 R6 for each secured field code with backdoor enabled
        for (int s = 0; s < 4; s++) begin
            if (s == 2) continue;
            do_reset(8'hA0 | 8'(s));
            pulse_start();
            wr_range(0, 6, 1'b0);
            check("R5 no unlock before byte 7", 32'(unlock), 0);
            check("R5 still secured", 32'(secured), 1);
            wr(7, kb(7), 1'b0);
            check("R6 unlock", 32'(unlock), 1);
            check("R6 secured low", 32'(secured), 0);
            check("R1 opt unchanged", 32'(opt), 32'(8'hA0 | 8'(s)));
            pulse_start();
            wr(0, 8'h00, 1'b0);
            check("R6 unlock persists", 32'(unlock), 1);
            do_reset(8'hA0 | 8'(s));
            check("R12 reset ends unlock", 32'(unlock), 0);
            check("R12 secured again", 32'(secured), 1);
        end

        // R4: unsecured field code does not arm
        do_reset(8'h82);
        pulse_start();
        wr_range(0, 7, 1'b0);
        check("R4 unsecured field no unlock", 32'(unlock), 0);
        check("R3 unsecured", 32'(secured), 0);

        // R4: writes without start are ignored
        do_reset(8'h81);
        wr_range(0, 7, 1'b0);
        check("R4 no start no unlock", 32'(unlock), 0);

        // R7: backdoor disabled
        do_reset(8'h01);
        pulse_start();
        wr_range(0, 7, 1'b0);
        check("R7 disabled no unlock", 32'(unlock), 0);
        check("R7 still secured", 32'(secured), 1);

        // R10: mismatch at each byte position blocks
        for (int k = 0; k < 8; k++) begin
            do_reset(8'h81);
            pulse_start();
            if (k > 0) wr_range(0, k - 1, 1'b0);
            wr(k, kb(k) ^ 8'h01, 1'b0);
            pulse_start();
            wr_range(0, 7, 1'b0);
            check("R10 blocked after mismatch", 32'(unlock), 0);
            check("R10 secured", 32'(secured), 1);
        end

        // R8: debug-origin bytes never count, but do not block
        do_reset(8'h81);
        pulse_start();
        wr_range(0, 7, 1'b1);
        check("R8 debug sequence no unlock", 32'(unlock), 0);
        pulse_start();
        wr_range(0, 7, 1'b0);
        check("R8 user unlock after debug", 32'(unlock), 1);

        do_reset(8'h81);
        pulse_start();
        wr_range(0, 3, 1'b0);
        wr(4, kb(4), 1'b1);
        wr_range(4, 7, 1'b0);
        check("R8 debug write aborts", 32'(unlock), 0);
        pulse_start();
        wr_range(0, 7, 1'b0);
        check("R8 restart after abort", 32'(unlock), 1);

        // R9: out-of-order index aborts
        do_reset(8'h81);
        pulse_start();
        wr(1, kb(1), 1'b0);
        wr_range(0, 7, 1'b0);
        check("R9 wrong first index aborts", 32'(unlock), 0);
        pulse_start();
        wr(0, kb(0), 1'b0);
        wr(1, kb(1), 1'b0);
        wr(3, kb(3), 1'b0);
        wr_range(3, 7, 1'b0);
        check("R9 skipped index aborts", 32'(unlock), 0);
        pulse_start();
        wr_range(0, 7, 1'b0);
        check("R9 not blocked by abort", 32'(unlock), 1);

        // R11: start and write in the same cycle
        do_reset(8'h81);
        pulse_start();
        wr_range(0, 3, 1'b0);
        @(negedge clk);
        start = 1'b1; kw_valid = 1'b1; kw_idx = 3'd4; kw_data = kb(4) ^ 8'hFF;
        @(negedge clk);
        start = 1'b0; kw_valid = 1'b0;
        wr_range(0, 6, 1'b0);
        check("R11 colliding write dropped", 32'(unlock), 0);
        wr(7, kb(7), 1'b0);
        check("R11 start wins, index 0", 32'(unlock), 1);

        finish_run();
    end
endmodule